// File: doc/BRIEF.md
# Storage Device Reset and Self-Test Sequencer

This block is the part of a serial storage device's command layer that handles resets and self-test. It covers three flows. The first is recovery from a link reset at power-up, which runs the power-up self-test. The second is the execute-diagnostic command. The third is the device-reset command.

The actual diagnostic routines, the encoding of status frames and the physical layer sit outside the block. They appear only as handshake inputs: a diagnostic-done strobe with a pass flag, an activity-halted level, and a status-sent acknowledge.

A link reset overrides everything. While it is asserted the controller parks in a reset-hold state. When the link reset is released, the controller runs the power-up self-test. Power-up self-test and command diagnostics report through one shared status path, which raises a status-frame request with a good/bad flag. Device reset first raises a halt request and waits for all activity to stop. Only then does it report good status. A software reset arriving during any diagnostic, halt or status phase preempts that flow in the same way as a link reset. Each finished status send ends with a one-cycle return-to-idle pulse.

Top module: `dev_rst_seq`

## Requirements
- R1: While the synchronous active-high `rst` is high on a clock edge, the controller enters the reset-hold state. In that state `sts_req`, `sts_good`, `halt_req` and `idle_pulse` are all 0.
- R2: A clock edge with `link_rst` high places the controller in the reset-hold state from any state. On that edge `link_rst` outranks `soft_rst`, `diag_done`, `halted`, `sts_ack` and `cmd_valid`, so all four outputs are 0 in the next cycle.
- R3: The reset-hold state is kept as long as `link_rst` stays high, and `diag_done` has no effect there. The first edge with `link_rst` low moves the controller to the power-up self-test state.
- R4: In the power-up self-test state, an edge with `diag_done` high starts a status send. The send is good (`sts_req`=1, `sts_good`=1) when `diag_pass` is 1 and bad (`sts_req`=1, `sts_good`=0) when `diag_pass` is 0.
- R5: A status send holds `sts_req` high, with `sts_good` unchanged, until an edge with `sts_ack` high. The next cycle shows `sts_req`=0 and `idle_pulse`=1, and the cycle after that shows `idle_pulse`=0. `sts_good` is 0 whenever `sts_req` is 0.
- R6: In idle, an edge with `cmd_valid` high and `cmd_class` equal to `CODE_DIAG` (default 1) starts the command diagnostic. Its `diag_done` then gives good or bad status according to `diag_pass`, exactly as in R4.
- R7: In idle, `cmd_valid` with `cmd_class` equal to `CODE_DEVRST` (default 2) raises `halt_req`. `halt_req` stays high, ignoring `diag_done`, until an edge with `halted` high. Then `halt_req` falls and a good status send begins. `halt_req` and `sts_req` are never both 1.
- R8: Any other `cmd_class` value (0 and 3 with `CMD_W`=2), and `cmd_valid` in any state other than idle, have no effect. `diag_done` and `halted` in idle also have no effect.
- R9: `soft_rst` high on an edge in the power-up self-test, command diagnostic, halt or status-send state moves the controller to the reset-hold state. It outranks `diag_done`, `halted` and `sts_ack` on that edge. With `link_rst` low the controller then proceeds into power-up self-test. `soft_rst` in idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_rst | input | 1 | Link reset level from the transport side (1 = asserted) |
| soft_rst | input | 1 | Software reset request seen in a received frame |
| cmd_valid | input | 1 | Command start pulse |
| cmd_class | input | CMD_W | Command class code qualifying `cmd_valid` |
| diag_done | input | 1 | Diagnostic routine finished |
| diag_pass | input | 1 | Diagnostic result, 1 = pass, sampled with `diag_done` |
| halted | input | 1 | All outstanding commands and background activity have stopped |
| sts_ack | input | 1 | Requested status frame has been sent |
| sts_req | output | 1 | Request to send a status register frame |
| sts_good | output | 1 | Status flag for the request, 1 = good, 0 = bad |
| halt_req | output | 1 | Request to halt all outstanding and background activity |
| idle_pulse | output | 1 | One-cycle pulse on return to idle |

## Verification
The bench builds the block with `CMD_W`=2 and the default codes 1 and 2. This lets it sweep all four class values, covering both recognised commands and both unused ones. For each reachable phase (self-test, command diagnostic, halt, status send, idle) it applies every combination of pass and fail, acknowledge delays of 0 to 3 cycles, and a software or link reset together with competing handshakes. Each expected output vector follows from the flow order written in the requirements.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [2:0] {
        RS_LINK_HOLD = 3'd0,
        RS_SELFTEST  = 3'd1,
        RS_IDLE      = 3'd2,
        RS_CMD_TEST  = 3'd3,
        RS_QUIESCE   = 3'd4,
        RS_SEND_OK   = 3'd5,
        RS_SEND_ERR  = 3'd6
    } rsq_state_e;

    typedef struct packed {
        rsq_state_e st;
        logic       idle_pls;
    } rsq_regs_t;

    typedef struct packed {
        logic is_diag;
        logic is_reset;
    } rsq_cmd_t;

endpackage

// File: rtl/rsq_cmd_dec.sv
module rsq_cmd_dec
    import rsq_pkg::*;
#(
    parameter int CMD_W       = 2,
    parameter int CODE_DIAG   = 1,
    parameter int CODE_DEVRST = 2
) (
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_class,
    output rsq_cmd_t         dec
);

    localparam logic [CMD_W-1:0] DIAG_C   = CMD_W'(CODE_DIAG);
    localparam logic [CMD_W-1:0] DEVRST_C = CMD_W'(CODE_DEVRST);

    always_comb begin
        dec.is_diag  = cmd_valid && (cmd_class == DIAG_C);
        dec.is_reset = cmd_valid && (cmd_class == DEVRST_C);
    end

endmodule

// File: rtl/rsq_fsm.sv
module rsq_fsm
    import rsq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      link_rst,
    input  logic      soft_rst,
    input  rsq_cmd_t  dec,
    input  logic      diag_done,
    input  logic      diag_pass,
    input  logic      halted,
    input  logic      sts_ack,
    output rsq_regs_t regs
);

    rsq_regs_t r_d, r_q;

    always_comb begin
        r_d          = r_q;
        r_d.idle_pls = 1'b0;
        if (link_rst) begin
            r_d.st = RS_LINK_HOLD;
        end else begin
            unique case (r_q.st)
                RS_LINK_HOLD: r_d.st = RS_SELFTEST;
                RS_SELFTEST, RS_CMD_TEST: begin
                    if (soft_rst)       r_d.st = RS_LINK_HOLD;
                    else if (diag_done) r_d.st = diag_pass ? RS_SEND_OK : RS_SEND_ERR;
                end
                RS_IDLE: begin
                    if (dec.is_diag)       r_d.st = RS_CMD_TEST;
                    else if (dec.is_reset) r_d.st = RS_QUIESCE;
                end
                RS_QUIESCE: begin
                    if (soft_rst)    r_d.st = RS_LINK_HOLD;
                    else if (halted) r_d.st = RS_SEND_OK;
                end
                RS_SEND_OK, RS_SEND_ERR: begin
                    if (soft_rst) begin
                        r_d.st = RS_LINK_HOLD;
                    end else if (sts_ack) begin
                        r_d.st       = RS_IDLE;
                        r_d.idle_pls = 1'b1;
                    end
                end
                default: r_d.st = RS_LINK_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{st: RS_LINK_HOLD, idle_pls: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign regs = r_q;

endmodule

// File: rtl/rsq_outmap.sv
module rsq_outmap
    import rsq_pkg::*;
(
    input  rsq_state_e st,
    output logic       sts_req,
    output logic       sts_good,
    output logic       halt_req
);

    always_comb begin
        sts_req  = (st == RS_SEND_OK) || (st == RS_SEND_ERR);
        sts_good = (st == RS_SEND_OK);
        halt_req = (st == RS_QUIESCE);
    end

endmodule

// File: rtl/dev_rst_seq.sv
module dev_rst_seq
    import rsq_pkg::*;
#(
    parameter int CMD_W       = 2,
    parameter int CODE_DIAG   = 1,
    parameter int CODE_DEVRST = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             link_rst,
    input  logic             soft_rst,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_class,
    input  logic             diag_done,
    input  logic             diag_pass,
    input  logic             halted,
    input  logic             sts_ack,
    output logic             sts_req,
    output logic             sts_good,
    output logic             halt_req,
    output logic             idle_pulse
);

    rsq_cmd_t  dec;
    rsq_regs_t regs;

    rsq_cmd_dec #(
        .CMD_W      (CMD_W),
        .CODE_DIAG  (CODE_DIAG),
        .CODE_DEVRST(CODE_DEVRST)
    ) u_dec (
        .cmd_valid(cmd_valid),
        .cmd_class(cmd_class),
        .dec      (dec)
    );

    rsq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .link_rst (link_rst),
        .soft_rst (soft_rst),
        .dec      (dec),
        .diag_done(diag_done),
        .diag_pass(diag_pass),
        .halted   (halted),
        .sts_ack  (sts_ack),
        .regs     (regs)
    );

    rsq_outmap u_out (
        .st      (regs.st),
        .sts_req (sts_req),
        .sts_good(sts_good),
        .halt_req(halt_req)
    );

    assign idle_pulse = regs.idle_pls;

endmodule

// File: rtl/rsq_checker.sv
module rsq_checker (
    input logic clk,
    input logic rst,
    input logic link_rst,
    input logic soft_rst,
    input logic halted,
    input logic sts_ack,
    input logic sts_req,
    input logic sts_good,
    input logic halt_req,
    input logic idle_pulse
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!sts_req && !sts_good && !halt_req && !idle_pulse));

    p_link_override_r2: assert property (@(posedge clk) disable iff (rst)
        link_rst |=> (!sts_req && !halt_req && !idle_pulse));

    p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (sts_req && !sts_ack && !link_rst && !soft_rst) |=> (sts_req && $stable(sts_good)));

    p_ack_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        (sts_req && sts_ack && !link_rst && !soft_rst) |=> (idle_pulse && !sts_req));

    p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
        idle_pulse |=> !idle_pulse);

    p_flag_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !sts_req |-> !sts_good);

    p_halt_to_good_r7: assert property (@(posedge clk) disable iff (rst)
        (halt_req && halted && !link_rst && !soft_rst) |=> (sts_req && sts_good && !halt_req));

    p_req_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        !(sts_req && halt_req));

    p_soft_preempt_r9: assert property (@(posedge clk) disable iff (rst)
        (soft_rst && (sts_req || halt_req)) |=> (!sts_req && !halt_req && !idle_pulse));

endmodule

bind dev_rst_seq rsq_checker u_rsq_chk (
    .clk       (clk),
    .rst       (rst),
    .link_rst  (link_rst),
    .soft_rst  (soft_rst),
    .halted    (halted),
    .sts_ack   (sts_ack),
    .sts_req   (sts_req),
    .sts_good  (sts_good),
    .halt_req  (halt_req),
    .idle_pulse(idle_pulse)
);

// File: tb/dev_rst_seq_bench.sv
`timescale 1ns/1ps
module dev_rst_seq_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       link_rst = 1'b0;
    logic       soft_rst = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_class = 2'd0;
    logic       diag_done = 1'b0;
    logic       diag_pass = 1'b0;
    logic       halted = 1'b0;
    logic       sts_ack = 1'b0;
    logic       sts_req, sts_good, halt_req, idle_pulse;
    logic [3:0] obs;

    int n_chk = 0;
    int n_err = 0;

    localparam logic [3:0] O_NONE = 4'b0000;
    localparam logic [3:0] O_GOOD = 4'b1100;
    localparam logic [3:0] O_BAD  = 4'b1000;
    localparam logic [3:0] O_HALT = 4'b0010;
    localparam logic [3:0] O_PLS  = 4'b0001;

    always #2.5 clk = ~clk;

    dev_rst_seq #(.CMD_W(2), .CODE_DIAG(1), .CODE_DEVRST(2)) u_dev_rst_seq (
        .clk(clk), .rst(rst), .link_rst(link_rst), .soft_rst(soft_rst),
        .cmd_valid(cmd_valid), .cmd_class(cmd_class), .diag_done(diag_done),
        .diag_pass(diag_pass), .halted(halted), .sts_ack(sts_ack),
        .sts_req(sts_req), .sts_good(sts_good), .halt_req(halt_req),
        .idle_pulse(idle_pulse)
    );

    assign obs = {sts_req, sts_good, halt_req, idle_pulse};

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [3:0] exp);
        n_chk++;
        if (obs !== exp) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b", tag, obs, exp);
        end
    endtask

    task automatic boot(input logic pass);
        rst = 1'b1; link_rst = 1'b0;
        step();
        chk("R1 reset-hold outputs", O_NONE);
        rst = 1'b0;
        step();
        chk("R4 self-test waits", O_NONE);
        diag_pass = pass; diag_done = 1'b1;
        step();
        diag_done = 1'b0;
        chk("R4 self-test status", pass ? O_GOOD : O_BAD);
    endtask

    task automatic finish_send();
        sts_ack = 1'b1;
        step();
        sts_ack = 1'b0;
        chk("R5 idle pulse after ack", O_PLS);
        step();
        chk("R5 pulse lasts one cycle", O_NONE);
    endtask

    task automatic go_idle();
        boot(1'b1);
        finish_send();
    endtask

    task automatic issue(input logic [1:0] code);
        cmd_valid = 1'b1; cmd_class = code;
        step();
        cmd_valid = 1'b0; cmd_class = 2'd0;
    endtask

    task automatic reach_phase(input int ph);
        case (ph)
            0: begin rst = 1'b1; step(); rst = 1'b0; step(); end
            1: begin go_idle(); issue(2'd1); end
            2: begin go_idle(); issue(2'd2); chk("R7 halt raised", O_HALT); end
            3: boot(1'b1);
            default: go_idle();
        endcase
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        // R1 and R3: reset-hold kept under link reset, diag_done ignored
        rst = 1'b1; link_rst = 1'b1;
        step();
        chk("R1 reset state", O_NONE);
        rst = 1'b0; diag_done = 1'b1; diag_pass = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R3 held while link reset", O_NONE);
        end
        diag_done = 1'b0; link_rst = 1'b0;
        step();
        chk("R3 release to self-test", O_NONE);
        step();
        chk("R4 self-test waits for done", O_NONE);
        diag_pass = 1'b0; diag_done = 1'b1;
        step();
        diag_done = 1'b0;
        chk("R4 fail gives bad status", O_BAD);
        finish_send();

        // R4 and R5: pass/fail with acknowledge delays
        for (int p = 0; p < 2; p++) begin
            for (int dly = 0; dly < 4; dly++) begin
                boot(p[0]);
                for (int k = 0; k < dly; k++) begin
                    step();
                    chk("R5 request held until ack", p[0] ? O_GOOD : O_BAD);
                end
                finish_send();
            end
        end

        // R6, R7, R8: every class code from idle
        for (int code = 0; code < 4; code++) begin
            for (int p = 0; p < 2; p++) begin
                go_idle();
                issue(code[1:0]);
                if (code == 1) begin
                    chk("R6 diag running", O_NONE);
                    diag_pass = p[0]; diag_done = 1'b1;
                    step();
                    diag_done = 1'b0;
                    chk("R6 command diag status", p[0] ? O_GOOD : O_BAD);
                    finish_send();
                end else if (code == 2) begin
                    chk("R7 halt request", O_HALT);
                    diag_pass = 1'b0; diag_done = 1'b1;
                    step();
                    diag_done = 1'b0;
                    chk("R7 diag_done ignored while halting", O_HALT);
                    for (int k = 0; k < p + 1; k++) begin
                        step();
                        chk("R7 halt held", O_HALT);
                    end
                    halted = 1'b1;
                    step();
                    halted = 1'b0;
                    chk("R7 good status after halt", O_GOOD);
                    finish_send();
                end else begin
                    chk("R8 unused code ignored", O_NONE);
                    diag_pass = 1'b1; diag_done = 1'b1;
                    step();
                    diag_done = 1'b0;
                    chk("R8 diag_done ignored in idle", O_NONE);
                    halted = 1'b1;
                    step();
                    halted = 1'b0;
                    chk("R8 halted ignored in idle", O_NONE);
                    issue(2'd2);
                    chk("R8 still idle afterwards", O_HALT);
                    halted = 1'b1;
                    step();
                    halted = 1'b0;
                    finish_send();
                end
            end
        end

        // R8: commands outside idle
        go_idle();
        issue(2'd1);
        issue(2'd2);
        chk("R8 command during diag ignored", O_NONE);
        diag_pass = 1'b1; diag_done = 1'b1;
        step();
        diag_done = 1'b0;
        chk("R6 status after diag", O_GOOD);
        issue(2'd2);
        chk("R8 command during send ignored", O_GOOD);
        finish_send();

        // R9: software reset in each active phase, with competing handshakes
        for (int ph = 0; ph < 4; ph++) begin
            reach_phase(ph);
            soft_rst = 1'b1; diag_done = 1'b1; diag_pass = 1'b1;
            halted = 1'b1; sts_ack = 1'b1;
            step();
            soft_rst = 1'b0; diag_done = 1'b0; halted = 1'b0; sts_ack = 1'b0;
            chk("R9 soft reset preempts", O_NONE);
            step();
            chk("R9 into self-test", O_NONE);
            halted = 1'b1;
            step();
            halted = 1'b0;
            chk("R9 not halting after soft reset", O_NONE);
            diag_pass = 1'b0; diag_done = 1'b1;
            step();
            diag_done = 1'b0;
            chk("R9 self-test status after soft reset", O_BAD);
            finish_send();
        end

        // R9: software reset in idle is ignored
        go_idle();
        soft_rst = 1'b1;
        step();
        soft_rst = 1'b0;
        chk("R9 soft reset in idle quiet", O_NONE);
        issue(2'd2);
        chk("R9 still idle after soft reset", O_HALT);
        halted = 1'b1;
        step();
        halted = 1'b0;
        finish_send();

        // R2: link reset from every phase outranks everything
        for (int ph = 0; ph < 5; ph++) begin
            reach_phase(ph);
            link_rst = 1'b1; soft_rst = 1'b1; diag_done = 1'b1; diag_pass = 1'b1;
            halted = 1'b1; sts_ack = 1'b1; cmd_valid = 1'b1; cmd_class = 2'd2;
            step();
            chk("R2 link reset forces hold", O_NONE);
            step();
            chk("R3 hold kept", O_NONE);
            soft_rst = 1'b0; diag_done = 1'b0; halted = 1'b0; sts_ack = 1'b0;
            cmd_valid = 1'b0; cmd_class = 2'd0; link_rst = 1'b0;
            step();
            chk("R3 leave hold", O_NONE);
            step();
            chk("R3 in self-test", O_NONE);
            diag_pass = 1'b1; diag_done = 1'b1;
            step();
            diag_done = 1'b0;
            chk("R4 status after link reset", O_GOOD);
            finish_send();
        end

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule